// File: doc/BRIEF.md
# Instruction Cycle and Flow Controller

This block sequences a small accumulator processor that runs 13-bit instruction words. It divides the oscillator clock into instruction cycles of two clocks and raises an execute strobe on the second clock of each one. The state change for the instruction on `instr_i` happens at the edge that ends that clock. The block holds the program counter and presents it as the fetch address. Program memory is expected to return the word at that address combinationally. The block also keeps a hardware return stack, the global interrupt-enable flag and the sleep state, and it pulses a watchdog-clear output.

The data path executes the arithmetic and tells the block, through `pc_wr_i` and `pc_wdata_i`, that the current instruction's result goes to the program-counter register. Every instruction that changes the flow costs a second instruction cycle. This covers a result written to the PC, a subroutine call, a return and a return-from-interrupt. During that second cycle the sequential word already fetched behind the instruction is thrown away as a no-operation. Arithmetic and interrupt vectoring are handled elsewhere.

Top module: `insn_flow_ctrl`

## Requirements
- R1: An instruction cycle is two clocks. `exec_o` is high on the second clock only. A sequential instruction advances the fetch address by one, and the next `exec_o` comes two clocks later.
- R2: The program counter is 10 bits wide and steps from 0x3FF to 0x000.
- R3: A flow-changing instruction takes two instruction cycles. Such an instruction has `pc_wr_i` high while executing, or is a call, a return or a return-from-interrupt. The next `exec_o` comes four clocks later, at the target address. The target is `pc_wdata_i` for a PC write.
- R4: In the extra cycle the fetch address shows the word after the flow-changing instruction. `exec_o` stays low. That word has no effect, whether it is a PC write, a return, a return-from-interrupt or an interrupt enable or disable.
- R5: A word whose bits [12:10] are 3'b100 is a call. It jumps to bits [9:0] and pushes its own address plus one.
- R6: Word 0x0012 pops the return stack into the PC. Word 0x0013 does the same and also sets the interrupt enable.
- R7: The return stack holds 8 entries. A push onto a full stack drops the oldest entry. A pop from an empty stack yields address 0x000.
- R8: Word 0x0010 sets `int_en_o` and word 0x0011 clears it, both effective after the executing clock.
- R9: Word 0x0004 raises `wdt_clr_o` for its executing clock.
- R10: Word 0x0003 also raises `wdt_clr_o` and then sets `sleep_o`. While asleep no instruction executes and the fetch address stays at the next address.
- R11: While `rst_ni` is low, the fetch address is 0, `int_en_o` is 0, `sleep_o` is 0, `exec_o` is 0 and the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 13 | Instruction word at the fetch address |
| pc_wr_i | input | 1 | Result of the current instruction targets the PC register |
| pc_wdata_i | input | 10 | Value written to the PC register |
| fetch_addr_o | output | 10 | Program-memory fetch address |
| exec_o | output | 1 | Execute strobe, second clock of an executing cycle |
| int_en_o | output | 1 | Global interrupt enable |
| sleep_o | output | 1 | Sleep state, oscillator stopped |
| wdt_clr_o | output | 1 | Watchdog clear pulse |

## Verification
A wrong phase or bubble flag shows at once as an execute strobe two clocks early or late, or as an extra execution of the word after a jump. Logging the strobe clock of every executed address therefore catches it within one instruction. A corrupted return-stack pointer or count stays hidden until the next return, and then shows as a wrong fetch address four clocks after that return executes. Deep call chains that overflow the stack, and a final pop from an empty stack, bring such faults out. A wrong interrupt-enable or sleep state is visible on its own port from the clock after the instruction executes.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int unsigned INSN_W = 13;

  localparam logic [INSN_W-1:0] OP_SLEEP = 13'h0003;
  localparam logic [INSN_W-1:0] OP_WDCLR = 13'h0004;
  localparam logic [INSN_W-1:0] OP_IEN   = 13'h0010;
  localparam logic [INSN_W-1:0] OP_IDIS  = 13'h0011;
  localparam logic [INSN_W-1:0] OP_RET   = 13'h0012;
  localparam logic [INSN_W-1:0] OP_RETI  = 13'h0013;
  localparam logic [2:0]        CALL_PFX = 3'b100;

  typedef struct packed {
    logic call;
    logic ret;
    logic reti;
    logic ien;
    logic idis;
    logic sleep;
    logic wdclr;
  } flow_dec_t;
endpackage

// File: rtl/insn_flow_dec.sv
module insn_flow_dec
  import flow_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output flow_dec_t         dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.call  = (instr_i[INSN_W-1 -: 3] == CALL_PFX);
    dec_o.ret   = (instr_i == OP_RET);
    dec_o.reti  = (instr_i == OP_RETI);
    dec_o.ien   = (instr_i == OP_IEN);
    dec_o.idis  = (instr_i == OP_IDIS);
    dec_o.sleep = (instr_i == OP_SLEEP);
    dec_o.wdclr = (instr_i == OP_WDCLR);
  end
endmodule

// File: rtl/icyc_phase.sv
module icyc_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= 1'b0;
    else if (run_i) phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;

  // R1
  phase_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_next, ptr_prev;
  logic [CW-1:0] cnt_q;
  logic          empty, full;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign ptr_next = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_prev = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;
  assign top_o    = empty ? '0 : mem_q[ptr_prev];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_data_i;
      ptr_q        <= ptr_next;
      if (!full) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      ptr_q <= ptr_prev;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  push_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty);
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/insn_flow_ctrl.sv
module insn_flow_ctrl
  import flow_pkg::*;
#(
  parameter int unsigned PC_W      = 10,
  parameter int unsigned STK_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] instr_i,
  input  logic              pc_wr_i,
  input  logic [PC_W-1:0]   pc_wdata_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic              exec_o,
  output logic              int_en_o,
  output logic              sleep_o,
  output logic              wdt_clr_o
);
  flow_dec_t       dec;
  logic            phase;
  logic            sleep_q, bubble_q, ie_q;
  logic [PC_W-1:0] pc_q, tgt_q, pc_inc, stk_top, target;
  logic            exec, redirect;

  insn_flow_dec u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  icyc_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (!sleep_q),
    .phase_o (phase)
  );

  ret_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (exec && dec.call),
    .pop_i       (exec && (dec.ret || dec.reti)),
    .push_data_i (pc_inc),
    .top_o       (stk_top)
  );

  assign exec     = phase && !bubble_q && !sleep_q;
  assign pc_inc   = pc_q + 1'b1;
  assign redirect = pc_wr_i || dec.call || dec.ret || dec.reti;

  always_comb begin
    if (pc_wr_i)       target = pc_wdata_i;
    else if (dec.call) target = instr_i[PC_W-1:0];
    else               target = stk_top;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      tgt_q    <= '0;
      bubble_q <= 1'b0;
    end else if (exec) begin
      pc_q <= pc_inc;
      if (redirect) begin
        tgt_q    <= target;
        bubble_q <= 1'b1;
      end
    end else if (phase && bubble_q && !sleep_q) begin
      pc_q     <= tgt_q;
      bubble_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= 1'b0;
      sleep_q <= 1'b0;
    end else if (exec) begin
      if (dec.ien || dec.reti) ie_q <= 1'b1;
      else if (dec.idis)       ie_q <= 1'b0;
      if (dec.sleep) sleep_q <= 1'b1;
    end
  end

  assign fetch_addr_o = pc_q;
  assign exec_o       = exec;
  assign int_en_o     = ie_q;
  assign sleep_o      = sleep_q;
  assign wdt_clr_o    = exec && (dec.sleep || dec.wdclr);

  // R1
  exec_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
  // R3
  redirect_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && redirect) |=> (bubble_q && !exec_o));
  // R4
  bubble_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bubble_q && !exec_o) |=> ($stable(ie_q) && !sleep_q));
  // R8
  ien_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && dec.ien) |=> int_en_o);
  // R10
  sleep_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |=> ($stable(pc_q) && sleep_q && !exec_o));
endmodule

// File: tb/tb_insn_flow_ctrl.sv
module tb_insn_flow_ctrl;
  localparam int PC_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] instr;
  logic        pc_wr;
  logic [9:0]  pc_wdata;
  logic [9:0]  fetch_addr;
  logic        exec, int_en, sleep, wdt_clr;

  logic [12:0] mem [1024];
  int          n_chk = 0, n_err = 0;
  int          cyc = 0, n_tr = 0, n_wdt = 0;
  logic [9:0]  tr_addr [64];
  logic        tr_ie [64];
  int          tr_cyc [64];
  logic [9:0]  exp_addr [64];
  logic        exp_ie [64];
  logic        exp_redir [64];
  int          n_exp;
  bit          patch_en = 0;
  logic [12:0] patch_val;
  bit          timed_out = 0;

  always #10 clk = ~clk;

  assign instr    = mem[fetch_addr];
  assign pc_wr    = (instr[12:10] == 3'b111);  // bench-side PC write
  assign pc_wdata = instr[9:0];

  insn_flow_ctrl dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .instr_i      (instr),
    .pc_wr_i      (pc_wr),
    .pc_wdata_i   (pc_wdata),
    .fetch_addr_o (fetch_addr),
    .exec_o       (exec),
    .int_en_o     (int_en),
    .sleep_o      (sleep),
    .wdt_clr_o    (wdt_clr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (wdt_clr) n_wdt = n_wdt + 1;
      if (exec && n_tr < 64) begin
        tr_addr[n_tr] = fetch_addr;
        tr_ie[n_tr]   = int_en;
        tr_cyc[n_tr]  = cyc;
        n_tr = n_tr + 1;
        if (patch_en && n_tr == 2) mem[0] = patch_val;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 13'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fetch_addr == 10'h000, "R11 fetch", fetch_addr, 0);
    chk(!int_en && !sleep && !exec && !wdt_clr, "R11 flags",
        {int_en, sleep, exec, wdt_clr}, 0);
    cyc = 0; n_tr = 0; n_wdt = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_to_sleep();
    int lim = 0;
    while (!sleep && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    if (!sleep) begin
      timed_out = 1;
      chk(0, "watchdog", lim, 0);
    end
  endtask

  task automatic check_trace(input string tag, input logic [9:0] final_fa,
                             input logic final_ie, input int wdt_exp);
    logic [9:0] fa;
    chk(n_tr == n_exp, {tag, " R3 trace length"}, n_tr, n_exp);
    for (int i = 0; i < n_exp && i < n_tr; i++) begin
      chk(tr_addr[i] == exp_addr[i], {tag, " R3 exec addr"}, tr_addr[i], exp_addr[i]);
      chk(tr_ie[i] == exp_ie[i], {tag, " R8 ie at exec"}, tr_ie[i], exp_ie[i]);
      if (i > 0)
        chk(tr_cyc[i] - tr_cyc[i-1] == (exp_redir[i-1] ? 4 : 2),
            {tag, " R1 exec spacing"}, tr_cyc[i] - tr_cyc[i-1], exp_redir[i-1] ? 4 : 2);
    end
    chk(sleep == 1'b1, {tag, " R10 sleep"}, sleep, 1);
    chk(fetch_addr == final_fa, {tag, " R10 fetch at sleep"}, fetch_addr, final_fa);
    chk(int_en == final_ie, {tag, " R8 final ie"}, int_en, final_ie);
    chk(n_wdt == wdt_exp, {tag, " R9 wdt pulses"}, n_wdt, wdt_exp);
    fa = fetch_addr;
    repeat (12) @(negedge clk);
    chk(fetch_addr == fa && !exec, {tag, " R10 frozen"}, fetch_addr, fa);
  endtask

  task automatic push_exp(input logic [9:0] a, input logic ie, input logic rd);
    exp_addr[n_exp] = a; exp_ie[n_exp] = ie; exp_redir[n_exp] = rd;
    n_exp++;
  endtask

  initial begin
    // Program A: ie, call/return, wdt, ignored bubble words (R4, R5, R6, R8, R9)
    clear_mem();
    mem[10'h000] = 13'h0010;            // ENI
    mem[10'h002] = 13'h1020;            // CALL 020
    mem[10'h003] = 13'h0011;            // DISI (bubble after call, then executed)
    mem[10'h004] = 13'h0003;            // SLEP
    mem[10'h020] = 13'h0004;            // WDTC
    mem[10'h021] = 13'h0012;            // RET
    mem[10'h022] = 13'h1E00;            // PC write 200 in bubble: ignored
    patch_en = 0;
    do_reset();
    n_exp = 0;
    push_exp(10'h000, 0, 0); push_exp(10'h001, 1, 0); push_exp(10'h002, 1, 1);
    push_exp(10'h020, 1, 0); push_exp(10'h021, 1, 1); push_exp(10'h003, 1, 0);
    push_exp(10'h004, 0, 0);
    run_to_sleep();
    check_trace("A R5 R6", 10'h005, 1'b0, 2);

    // Program B: PC write, wrap, RETI ignored in bubble (R2, R3, R4)
    clear_mem();
    mem[10'h000] = 13'h1FFE;            // PC write 3FE
    mem[10'h001] = 13'h0013;            // RETI in bubble: ignored
    patch_en = 1; patch_val = 13'h0003; // 000 becomes SLEP after first pass
    do_reset();
    chk(sleep == 1'b0, "R11 reset leaves sleep", sleep, 0);
    n_exp = 0;
    push_exp(10'h000, 0, 1); push_exp(10'h3FE, 0, 0); push_exp(10'h3FF, 0, 0);
    push_exp(10'h000, 0, 0);
    run_to_sleep();
    check_trace("B R2 R4", 10'h001, 1'b0, 1);

    // Program C: 9 nested calls overflow 8-deep stack, RETI, empty pop (R6, R7)
    clear_mem();
    for (int k = 0; k <= 8; k++) mem[k*16] = 13'h1000 | 13'((k + 1) * 16);
    for (int k = 1; k <= 8; k++) mem[k*16 + 1] = 13'h0012;
    mem[10'h090] = 13'h0013;            // RETI
    patch_en = 1; patch_val = 13'h0003;
    do_reset();
    n_exp = 0;
    for (int k = 0; k <= 8; k++) push_exp(10'(k * 16), 0, 1);
    push_exp(10'h090, 0, 1);
    for (int k = 8; k >= 1; k--) push_exp(10'(k * 16 + 1), 1, 1);
    push_exp(10'h000, 1, 0);            // R7 empty pop -> 000
    run_to_sleep();
    check_trace("C R7", 10'h001, 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule